// File: doc/BRIEF.md
# Serial Programming-Enable Sequencer

This block brings a target device into serial programming mode. A single-cycle `start` pulse captures an 8-bit device code and launches a fixed sequence. The sequencer first drives the target reset line through a timed reset step and waits for a further delay. It then shifts a two-byte enable instruction out over a bit-banged SPI master that it contains. SCK high and low times are set by parameters, and so are all delays, in clock cycles.

For one band of device codes the third byte is read back and compared with the expected echo. On a mismatch the sequencer sends a filler byte and one lone SCK pulse, which slips the bit alignment by one position, then repeats the instruction. It makes at most 32 attempts. For other codes the third byte is sent blind. A trailing filler byte (omitted for one code) and a settle delay finish the run. When the run ends, `done` goes high, and `syncFail` goes high with it if every attempt failed.

Top module: `prog_enable_seq`

## Requirements
- R1: After `rstN` is released, `tgtReset`, `sck`, `mosi`, `done` and `syncFail` are all 0.
- R2: A start with device code 0x86 holds `tgtReset` at 0 for the cycle of acceptance plus RST_CYC cycles and then drives it to 1. Any other code drives `tgtReset` to 1 for that span and then to 0. The line keeps its final level after the run, including after a synchronization failure.
- R3: Each SCK pulse is SCK_LO cycles low followed by SCK_HI cycles high. MOSI changes only while SCK is low, and MISO is sampled at the clock edge on which SCK rises.
- R4: Bytes are shifted most significant bit first. Every attempt begins with 0xAC followed by 0x53.
- R5: For device codes 0x20 to 0x7F inclusive, the third byte is a read with MOSI held at 0. A read value of 0x53 ends the handshake successfully.
- R6: On a read mismatch the sequencer sends 0x00, then one lone SCK pulse with MOSI at 0, then retries from 0xAC. After the 32nd mismatch no filler or pulse is sent; the run continues with the trailing byte and ends with `syncFail` = 1.
- R7: For codes outside 0x20 to 0x7F, the third byte is 0x00 and is not checked. The trailing 0x00 byte is sent for every code except 0x86.
- R8: `done` first reads 1 exactly S cycles after the start-accepting edge, where S is the sum of the costs of the steps. A wait of n cycles costs n+1, a byte costs 8*(SCK_LO+SCK_HI)+1, and a lone pulse costs SCK_LO+SCK_HI+1. `done` and `syncFail` hold until the next accepted start, which clears both.
- R9: Between shifted bytes and after the run, `sck` and `mosi` rest at 0.
- R10: `start` pulses and `devCode` changes that arrive while a run is in progress have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the sequencer is idle |
| devCode | input | 8 | Device code, captured on an accepted start |
| miso | input | 1 | Serial data from the target |
| tgtReset | output | 1 | Target reset line |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| done | output | 1 | Run finished; held until the next start |
| syncFail | output | 1 | All attempts failed; valid while done |

## Verification
Every output in a run is tied to a cycle index counted from the edge that accepts `start`. The reset line is due at index 0 and flips at index RST_CYC+1. `done` must read 0 at index S-1 and 1 at index S, where the bench computes S from the cost formula in R8 for the device code and the number of forced mismatches. The bench advances one cycle at a time and samples every output on the falling edge at exactly these indices. A target model counts SCK rising edges and compares each MOSI bit against a stream built independently. It also returns a deliberately corrupted echo for a chosen number of attempts.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [1:0] {
    OP_WAIT  = 2'd0,
    OP_BYTE  = 2'd1,
    OP_PULSE = 2'd2
  } opKind_e;

  typedef enum logic [1:0] {
    W_RESET   = 2'd0,
    W_POSTRST = 2'd1,
    W_SETTLE  = 2'd2
  } waitSel_e;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic     go;
    opKind_e  kind;
    waitSel_e waitSel;
    logic [7:0] txByte;
  } opCmd_t;

  localparam logic [7:0] BYTE_ENABLE  = 8'hAC;
  localparam logic [7:0] BYTE_ECHO    = 8'h53;
  localparam logic [7:0] BYTE_FILL    = 8'h00;
  localparam logic [7:0] DEV_RST_HIGH = 8'h86;
  localparam logic [7:0] DEV_CHK_LO   = 8'h20;
  localparam logic [7:0] DEV_CHK_HI   = 8'h7F;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pes_datapath.sv
module pes_datapath
  import pes_pkg::*;
#(
  parameter int unsigned SCK_HI   = 6,
  parameter int unsigned SCK_LO   = 2,
  parameter int unsigned RST_CYC  = 2000,
  parameter int unsigned POST_CYC = 2000,
  parameter int unsigned END_CYC  = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  opCmd_t     cmd,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       opDone,
  output logic [7:0] rxByte
);

  localparam int unsigned MAXCNT = maxOf(maxOf(SCK_HI, SCK_LO),
                                         maxOf(maxOf(RST_CYC, POST_CYC), END_CYC));
  localparam int unsigned CW = $clog2(MAXCNT + 1);

  logic          active;
  opKind_e       kind;
  logic          phaseHigh;
  logic [2:0]    bitIdx;
  logic [CW-1:0] cnt;
  logic [CW-1:0] waitLast;
  logic [CW-1:0] selLast;
  logic [7:0]    txSh;
  logic          isShift;
  logic          lowEnd;
  logic          highEnd;
  logic          lastBit;

  always_comb begin
    case (cmd.waitSel)
      W_RESET:   selLast = CW'(RST_CYC - 1);
      W_POSTRST: selLast = CW'(POST_CYC - 1);
      default:   selLast = CW'(END_CYC - 1);
    endcase
  end

  assign isShift = active && (kind != OP_WAIT);
  assign lowEnd  = isShift && !phaseHigh && (cnt == CW'(SCK_LO - 1));
  assign highEnd = isShift && phaseHigh && (cnt == CW'(SCK_HI - 1));
  assign lastBit = (kind == OP_PULSE) || (bitIdx == 3'd0);
  assign opDone  = (active && (kind == OP_WAIT) && (cnt == waitLast)) ||
                   (highEnd && lastBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      kind      <= OP_WAIT;
      phaseHigh <= 1'b0;
      bitIdx    <= 3'd0;
      cnt       <= '0;
      waitLast  <= '0;
      txSh      <= '0;
      rxByte    <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
    end else if (cmd.go) begin
      active    <= 1'b1;
      kind      <= cmd.kind;
      phaseHigh <= 1'b0;
      bitIdx    <= 3'd7;
      cnt       <= '0;
      waitLast  <= selLast;
      txSh      <= cmd.txByte;
      sck       <= 1'b0;
      mosi      <= (cmd.kind == OP_BYTE) ? cmd.txByte[7] : 1'b0;
    end else if (active) begin
      if (kind == OP_WAIT) begin
        if (opDone) active <= 1'b0;
        else        cnt    <= cnt + 1'b1;
      end else if (lowEnd) begin
        sck       <= 1'b1;
        phaseHigh <= 1'b1;
        cnt       <= '0;
        rxByte    <= {rxByte[6:0], miso};
      end else if (highEnd) begin
        sck       <= 1'b0;
        phaseHigh <= 1'b0;
        cnt       <= '0;
        if (lastBit) begin
          active <= 1'b0;
          mosi   <= 1'b0;
        end else begin
          bitIdx <= bitIdx - 1'b1;
          txSh   <= {txSh[6:0], 1'b0};
          mosi   <= txSh[6];
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pes_ctrl.sv
module pes_ctrl
  import pes_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] devCode,
  input  logic       opDone,
  input  logic [7:0] rxByte,
  output opCmd_t     cmd,
  output logic       tgtReset,
  output logic       done,
  output logic       syncFail
);

  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_POST, S_EN, S_ECHO, S_THIRD,
    S_FILL, S_LONE, S_FOURTH, S_SETTLE
  } state_e;

  state_e        state;
  logic          issued;
  logic [7:0]    devReg;
  logic [TW-1:0] tries;
  logic          failFlag;
  logic          checkDev;
  logic          rstHighDev;

  assign checkDev   = (devReg >= DEV_CHK_LO) && (devReg <= DEV_CHK_HI);
  assign rstHighDev = (devReg == DEV_RST_HIGH);

  always_comb begin
    cmd         = '0;
    cmd.go      = (state != S_IDLE) && !issued;
    cmd.kind    = OP_BYTE;
    cmd.waitSel = W_SETTLE;
    cmd.txByte  = BYTE_FILL;
    case (state)
      S_RST:    begin cmd.kind = OP_WAIT; cmd.waitSel = W_RESET;   end
      S_POST:   begin cmd.kind = OP_WAIT; cmd.waitSel = W_POSTRST; end
      S_SETTLE: begin cmd.kind = OP_WAIT; cmd.waitSel = W_SETTLE;  end
      S_EN:     cmd.txByte = BYTE_ENABLE;
      S_ECHO:   cmd.txByte = BYTE_ECHO;
      S_LONE:   cmd.kind = OP_PULSE;
      default:  cmd.txByte = BYTE_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      issued   <= 1'b0;
      devReg   <= '0;
      tries    <= '0;
      failFlag <= 1'b0;
      tgtReset <= 1'b0;
      done     <= 1'b0;
      syncFail <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start) begin
        devReg   <= devCode;
        tgtReset <= (devCode != DEV_RST_HIGH);
        done     <= 1'b0;
        syncFail <= 1'b0;
        failFlag <= 1'b0;
        tries    <= '0;
        issued   <= 1'b0;
        state    <= S_RST;
      end
    end else begin
      if (cmd.go) issued <= 1'b1;
      if (opDone) begin
        issued <= 1'b0;
        case (state)
          S_RST: begin
            tgtReset <= rstHighDev;
            state    <= S_POST;
          end
          S_POST:  state <= S_EN;
          S_EN:    state <= S_ECHO;
          S_ECHO:  state <= S_THIRD;
          S_THIRD: begin
            if (!checkDev) begin
              state <= rstHighDev ? S_SETTLE : S_FOURTH;
            end else if (rxByte == BYTE_ECHO) begin
              state <= S_FOURTH;
            end else if (tries == TW'(MAX_TRIES - 1)) begin
              failFlag <= 1'b1;
              state    <= S_FOURTH;
            end else begin
              tries <= tries + 1'b1;
              state <= S_FILL;
            end
          end
          S_FILL:   state <= S_LONE;
          S_LONE:   state <= S_EN;
          S_FOURTH: state <= S_SETTLE;
          S_SETTLE: begin
            done     <= 1'b1;
            syncFail <= failFlag;
            state    <= S_IDLE;
          end
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/prog_enable_seq.sv
module prog_enable_seq
  import pes_pkg::*;
#(
  parameter int unsigned SCK_HI    = 6,
  parameter int unsigned SCK_LO    = 2,
  parameter int unsigned RST_CYC   = 2000,
  parameter int unsigned POST_CYC  = 2000,
  parameter int unsigned END_CYC   = 500,
  parameter int unsigned MAX_TRIES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] devCode,
  input  logic       miso,
  output logic       tgtReset,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic       syncFail
);

  opCmd_t     cmd;
  logic       opDone;
  logic [7:0] rxByte;

  pes_ctrl #(.MAX_TRIES(MAX_TRIES)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .devCode(devCode),
    .opDone(opDone), .rxByte(rxByte), .cmd(cmd),
    .tgtReset(tgtReset), .done(done), .syncFail(syncFail)
  );

  pes_datapath #(
    .SCK_HI(SCK_HI), .SCK_LO(SCK_LO), .RST_CYC(RST_CYC),
    .POST_CYC(POST_CYC), .END_CYC(END_CYC)
  ) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso),
    .sck(sck), .mosi(mosi), .opDone(opDone), .rxByte(rxByte)
  );

endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
  parameter int unsigned SCK_HI = 6
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic tgtReset,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic syncFail
);

  logic [15:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    hiCnt <= '0;
    else if (sck) hiCnt <= hiCnt + 1'b1;
    else          hiCnt <= '0;
  end

  // R3: data held steady through the high phase
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R3: every high phase lasts SCK_HI cycles
  a_r3_sck_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sck) |-> (hiCnt == 16'(SCK_HI)));

  // R6: failure is only reported together with completion
  a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    syncFail |-> done);

  // R8: completion is cleared only by an accepted start
  a_r8_done_held: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(start));

  // R9: lines quiet once finished
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sck && !mosi));

  // R2: reset line never moves while bits are shifted
  a_r2_reset_steady_shift: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(tgtReset));

endmodule

bind prog_enable_seq pes_checker #(.SCK_HI(SCK_HI)) pesChk (
  .clk(clk), .rstN(rstN), .start(start), .tgtReset(tgtReset),
  .sck(sck), .mosi(mosi), .done(done), .syncFail(syncFail)
);

// File: tb/prog_enable_seq_test.sv
module prog_enable_seq_test;

  localparam int SCK_HI   = 3;
  localparam int SCK_LO   = 1;
  localparam int RST_CYC  = 5;
  localparam int POST_CYC = 4;
  localparam int END_CYC  = 3;
  localparam int TRIES    = 32;
  localparam int BITCYC   = SCK_HI + SCK_LO;
  localparam int BYC      = 8 * BITCYC + 1;
  localparam int PUC      = BITCYC + 1;
  localparam int ATT_BITS = 33;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] devCode = 8'h00;
  logic miso;
  logic tgtReset, sck, mosi, done, syncFail;

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;
  int riseCnt = 0;
  int bitErr = 0;
  int widthErr = 0;
  int hiRun = 0;
  int curFail = 0;
  int expLen = 0;
  bit expBits [0:2047];

  always #10 clk = ~clk;

  prog_enable_seq #(
    .SCK_HI(SCK_HI), .SCK_LO(SCK_LO), .RST_CYC(RST_CYC),
    .POST_CYC(POST_CYC), .END_CYC(END_CYC), .MAX_TRIES(TRIES)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .devCode(devCode), .miso(miso),
    .tgtReset(tgtReset), .sck(sck), .mosi(mosi), .done(done), .syncFail(syncFail)
  );

  function automatic logic [7:0] replyFor(input int k);
    if (k < curFail) return 8'h53 ^ (8'h01 << (k % 8));
    return 8'h53;
  endfunction

  // target model: echo window is bits 16..23 of each 33-bit attempt
  always_comb begin
    int k;
    int off;
    logic [7:0] r;
    k = riseCnt / ATT_BITS;
    off = riseCnt % ATT_BITS;
    r = replyFor(k);
    if (off >= 16 && off < 24) miso = r[7 - (off - 16)];
    else miso = 1'b0;
  end

  always @(posedge sck) begin
    if (riseCnt < 2048) begin
      if (riseCnt >= expLen || mosi !== expBits[riseCnt]) bitErr = bitErr + 1;
    end
    riseCnt = riseCnt + 1;
  end

  always @(negedge clk) begin
    cycleCount = cycleCount + 1;
    if (sck) hiRun = hiRun + 1;
    else begin
      if (hiRun != 0 && hiRun != SCK_HI) widthErr = widthErr + 1;
      hiRun = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      expBits[expLen] = b[i];
      expLen = expLen + 1;
    end
  endtask

  task automatic pushBit0();
    expBits[expLen] = 1'b0;
    expLen = expLen + 1;
  endtask

  task automatic runOne(input logic [7:0] dev, input int failN, input int injectAt);
    bit inRange;
    bit is86;
    bit expFail;
    int att;
    int S;
    expLen = 0;
    inRange = (dev >= 8'h20) && (dev <= 8'h7F);
    is86 = (dev == 8'h86);
    curFail = failN;
    expFail = inRange && (failN >= TRIES);
    S = (RST_CYC + 1) + (POST_CYC + 1) + (END_CYC + 1);
    if (inRange) begin
      att = (failN >= TRIES) ? TRIES - 1 : failN;
      for (int k = 0; k < att; k++) begin
        pushByte(8'hAC); pushByte(8'h53); pushByte(8'h00); pushByte(8'h00); pushBit0();
      end
      pushByte(8'hAC); pushByte(8'h53); pushByte(8'h00); pushByte(8'h00);
      S = S + att * (4 * BYC + PUC) + 4 * BYC;
    end else begin
      pushByte(8'hAC); pushByte(8'h53); pushByte(8'h00);
      if (!is86) pushByte(8'h00);
      S = S + (is86 ? 3 : 4) * BYC;
    end
    riseCnt = 0;
    bitErr = 0;
    widthErr = 0;
    @(negedge clk);
    devCode = dev;
    start = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= S; c++) begin
      @(negedge clk);
      start = (c == injectAt);
      if (c == 0) devCode = ~dev;
      if (c == 0)
        chk(tgtReset == !is86, "R2 reset first level", tgtReset, !is86);
      if (c == RST_CYC)
        chk(tgtReset == !is86, "R2 reset level held", tgtReset, !is86);
      if (c == RST_CYC + 1)
        chk(tgtReset == is86, "R2 reset second level", tgtReset, is86);
      if (c == S - 1)
        chk(done == 1'b0, "R8 done not early", done, 0);
      if (c == S) begin
        chk(done == 1'b1, "R8 done on time", done, 1);
        chk(syncFail == expFail, "R6 R5 syncFail", syncFail, expFail);
        chk(sck == 1'b0 && mosi == 1'b0, "R9 lines rest low", {sck, mosi}, 0);
        chk(tgtReset == is86, "R2 final reset level", tgtReset, is86);
        chk(riseCnt == expLen, "R4 R6 R7 sck pulse count", riseCnt, expLen);
        chk(bitErr == 0, "R4 R5 R7 mosi stream", bitErr, 0);
        chk(widthErr == 0, "R3 sck high width", widthErr, 0);
        if (injectAt >= 0)
          chk(riseCnt == expLen && done, "R10 start ignored while busy", riseCnt, expLen);
      end
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && syncFail == expFail, "R8 done held", {done, syncFail}, {1'b1, expFail});
  endtask

  initial begin
    while (cycleCount < 190000) @(negedge clk);
    errors = errors + 1;
    $display("FAIL watchdog actual=%0d expected=<190000", cycleCount);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(tgtReset == 0, "R1 tgtReset at reset", tgtReset, 0);
    chk(sck == 0 && mosi == 0, "R1 sck mosi at reset", {sck, mosi}, 0);
    chk(done == 0 && syncFail == 0, "R1 done syncFail at reset", {done, syncFail}, 0);
    // R7 R5: every device code, echo correct on the first try
    for (int d = 0; d < 256; d++)
      runOne(8'(d), 0, (d % 16 == 0) ? 20 : -1);
    // R6: retries with a corrupted echo, up to and past the limit
    runOne(8'h20, 1, 50);
    runOne(8'h7F, 2, -1);
    runOne(8'h45, 7, 300);
    runOne(8'h33, 31, -1);
    runOne(8'h20, 32, 1000);
    runOne(8'h7F, 40, -1);
    runOne(8'h86, 0, 12);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule